// File: doc/BRIEF.md
# Accumulator ALU with Condition Codes

This block is the arithmetic and logic stage of a small 8-bit accumulator processor. Each cycle it is handed the accumulator, an already-resolved operand, a 3-bit operation code and the current condition code register. It then forms a new 8-bit result and a new set of flags. It also forms the next values of a 16-bit stack pointer and a 16-bit index pair, which are moved by a signed 8-bit immediate. The sequencer decides when a result is valid by raising `upd_en`. On that cycle all four output registers load together.

Flag handling follows a fixed rule for each operation. Adds update every arithmetic flag, including a half-carry out of bit 3. The logical AND clears overflow and leaves half-carry and carry alone. The two arithmetic shifts pass a bit out through carry and derive overflow from the new sign and the new carry. The two pointer adjustments change no flag at all. The interrupt mask bit is always passed through unchanged.

Top module: `accu_alu_top`

## Requirements
- R1: With op code 0 (add), the result is (acc + opnd) mod 256. C is the carry out of bit 7 and H is the carry out of bit 3. V is 1 when acc and opnd have equal bit 7 and the result's bit 7 differs from theirs.
- R2: With op code 1 (add with carry), the result is (acc + opnd + C_in) mod 256. H, C and V follow the R1 rules with the incoming carry included.
- R3: With op code 2 (AND), the result is acc & opnd. V is cleared, and H and C keep their incoming values.
- R4: With op code 3 (shift left), the result is {acc[6:0],0}. C takes acc[7], V = N xor C (both taken after the shift), and H is kept.
- R5: With op code 4 (arithmetic shift right), the result is {acc[7],acc[7:1]}. C takes acc[0], V = N xor C (both taken after the shift), and H is kept.
- R6: For op codes 0 to 4, N equals result bit 7 and Z is 1 exactly when the 8-bit result is zero.
- R7: With op code 5, sp_q loads sp_in plus opnd sign-extended to 16 bits, modulo 2^16. For every other op code, sp_q loads sp_in unchanged.
- R8: With op code 6, hx_q loads hx_in plus opnd sign-extended to 16 bits, modulo 2^16. For every other op code, hx_q loads hx_in unchanged.
- R9: The CCR bits are ordered [5]=V, [4]=H, [3]=I, [2]=N, [1]=Z, [0]=C. No operation changes I.
- R10: For op codes 5, 6 and 7, res_q loads acc_in and ccr_q loads ccr_in unchanged. Op code 7 changes nothing else.
- R11: While upd_en is low, res_q, ccr_q, sp_q and hx_q hold their values.
- R12: A clock edge with rst_n low clears all four output registers to zero, whatever upd_en is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_en | input | 1 | Load enable for all output registers |
| op_sel | input | 3 | Operation code (see R1 to R10) |
| acc_in | input | 8 | Accumulator value |
| opnd_in | input | 8 | Resolved operand or signed immediate |
| ccr_in | input | 6 | Current flags, layout per R9 |
| sp_in | input | 16 | Current stack pointer |
| hx_in | input | 16 | Current index pair |
| res_q | output | 8 | Registered result |
| ccr_q | output | 6 | Registered flags |
| sp_q | output | 16 | Registered stack pointer |
| hx_q | output | 16 | Registered index pair |

## Verification
The bench targets operand pairs that separate the carry out of bit 3 from the carry out of bit 7. It also uses the signed overflow at 0x7F+1, and the wrap to zero that must raise Z and C together. A design that took half-carry from the wrong bit, or that derived overflow from carry, would show wrong H or V on these vectors. Flag preservation is checked by giving AND and the shifts an incoming H and C of 1 and confirming those bits survive. The pointer adjusts are run with negative immediates and a 16-bit wrap, so zero-extending the immediate or truncating the sum gives a wrong pointer. A flag write on a pointer op, a lost I bit, or a register that loads while upd_en is low all show up at the outputs.

// File: rtl/alu_pkg.sv
// Shared definitions for the accumulator ALU: operation codes and the
// bit positions of the condition code register. Assumes an 8-bit datapath.
package alu_pkg;
    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADC  = 3'd1,
        OP_AND  = 3'd2,
        OP_SHL  = 3'd3,
        OP_SHRA = 3'd4,
        OP_SPJ  = 3'd5,
        OP_HXJ  = 3'd6,
        OP_NOP  = 3'd7
    } op_e;

    localparam int CCR_W = 6;
    localparam int F_V = 5;
    localparam int F_H = 4;
    localparam int F_I = 3;
    localparam int F_N = 2;
    localparam int F_Z = 1;
    localparam int F_C = 0;
endpackage

// File: rtl/alu_adder.sv
// Adder with carry-in. Reports the carry out of the low nibble, the carry out
// of the top bit, and two's-complement overflow. Assumes DW >= 5.
module alu_adder #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    output logic [DW-1:0] sum,
    output logic          half_co,
    output logic          co,
    output logic          ovf
);
    localparam int NB = 4;

    logic [NB:0] lo;
    logic [DW:0] full;

    // Form the nibble sum for half-carry and the full-width sum for carry.
    always_comb begin
        lo      = {1'b0, a[NB-1:0]} + {1'b0, b[NB-1:0]} + {{NB{1'b0}}, cin};
        full    = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
        sum     = full[DW-1:0];
        half_co = lo[NB];
        co      = full[DW];
        ovf     = (a[DW-1] == b[DW-1]) && (full[DW-1] != a[DW-1]);
    end
endmodule

// File: rtl/alu_shifter.sv
// One-place shifter. A left shift fills bit 0 with zero. A right shift keeps
// the sign bit. The bit shifted out is reported on bit_out.
module alu_shifter #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] din,
    input  logic          go_right,
    output logic [DW-1:0] dout,
    output logic          bit_out
);
    // Select the shift direction and the bit that leaves the word.
    always_comb begin
        if (go_right) begin
            dout    = {din[DW-1], din[DW-1:1]};
            bit_out = din[0];
        end else begin
            dout    = {din[DW-2:0], 1'b0};
            bit_out = din[DW-1];
        end
    end
endmodule

// File: rtl/ptr_adjust.sv
// Adds a sign-extended immediate to a pointer when enabled, and passes the
// pointer through otherwise. Wraps modulo 2^PW. Assumes PW > IW.
module ptr_adjust #(
    parameter int PW = 16,
    parameter int IW = 8
) (
    input  logic [PW-1:0] base,
    input  logic [IW-1:0] imm,
    input  logic          en,
    output logic [PW-1:0] next
);
    logic [PW-1:0] imm_x;

    // Sign-extend the immediate and choose the adjusted or original pointer.
    always_comb begin
        imm_x = {{(PW-IW){imm[IW-1]}}, imm};
        next  = en ? base + imm_x : base;
    end
endmodule

// File: rtl/accu_alu_top.sv
// Accumulator ALU top. Selects an operation, builds the new condition codes
// under each operation's flag rule, and registers the result, flags and both
// pointers on upd_en. Assumes the operand is already fetched and resolved.
module accu_alu_top
    import alu_pkg::*;
#(
    parameter int DW = 8,
    parameter int PW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_en,
    input  logic [2:0]       op_sel,
    input  logic [DW-1:0]    acc_in,
    input  logic [DW-1:0]    opnd_in,
    input  logic [CCR_W-1:0] ccr_in,
    input  logic [PW-1:0]    sp_in,
    input  logic [PW-1:0]    hx_in,
    output logic [DW-1:0]    res_q,
    output logic [CCR_W-1:0] ccr_q,
    output logic [PW-1:0]    sp_q,
    output logic [PW-1:0]    hx_q
);
    op_e op;
    assign op = op_e'(op_sel);

    logic [DW-1:0] add_sum, sh_out, res_d;
    logic add_h, add_c, add_v, sh_c;
    logic [CCR_W-1:0] ccr_d;
    logic [PW-1:0] sp_d, hx_d;
    logic use_cin, sp_en, hx_en;

    assign use_cin = (op == OP_ADC) && ccr_in[F_C];
    assign sp_en   = (op == OP_SPJ);
    assign hx_en   = (op == OP_HXJ);

    alu_adder #(.DW(DW)) u_add (
        .a(acc_in), .b(opnd_in), .cin(use_cin),
        .sum(add_sum), .half_co(add_h), .co(add_c), .ovf(add_v)
    );

    alu_shifter #(.DW(DW)) u_shf (
        .din(acc_in), .go_right(op == OP_SHRA),
        .dout(sh_out), .bit_out(sh_c)
    );

    ptr_adjust #(.PW(PW), .IW(DW)) u_spj (
        .base(sp_in), .imm(opnd_in), .en(sp_en), .next(sp_d)
    );

    ptr_adjust #(.PW(PW), .IW(DW)) u_hxj (
        .base(hx_in), .imm(opnd_in), .en(hx_en), .next(hx_d)
    );

    // Pick the result and apply the flag-update rule of the selected operation.
    always_comb begin
        res_d = acc_in;
        ccr_d = ccr_in;
        unique case (op)
            OP_ADD, OP_ADC: begin
                res_d      = add_sum;
                ccr_d[F_V] = add_v;
                ccr_d[F_H] = add_h;
                ccr_d[F_C] = add_c;
            end
            OP_AND: begin
                res_d      = acc_in & opnd_in;
                ccr_d[F_V] = 1'b0;
            end
            OP_SHL, OP_SHRA: begin
                res_d      = sh_out;
                ccr_d[F_C] = sh_c;
                ccr_d[F_V] = sh_out[DW-1] ^ sh_c;
            end
            default: ;
        endcase
        if (op inside {OP_ADD, OP_ADC, OP_AND, OP_SHL, OP_SHRA}) begin
            ccr_d[F_N] = res_d[DW-1];
            ccr_d[F_Z] = (res_d == '0);
        end
    end

    // Load every output register on upd_en; clear them all on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            ccr_q <= '0;
            sp_q  <= '0;
            hx_q  <= '0;
        end else if (upd_en) begin
            res_q <= res_d;
            ccr_q <= ccr_d;
            sp_q  <= sp_d;
            hx_q  <= hx_d;
        end
    end

    // R9: the mask bit always reloads from its input.
    a_r9_mask_kept: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> ccr_q[F_I] == $past(ccr_in[F_I]));

    // R10: pointer ops and the no-op pass accumulator and flags straight through.
    a_r10_ptr_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_sel >= 3'd5) |=> (ccr_q == $past(ccr_in)) && (res_q == $past(acc_in)));

    // R11: nothing moves while the enable is low.
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(res_q) && $stable(ccr_q) && $stable(sp_q) && $stable(hx_q));

    // R6: the registered Z flag agrees with the registered result.
    a_r6_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_sel <= 3'd4) |=> ccr_q[F_Z] == (res_q == '0));

    // R5: the sign bit survives an arithmetic right shift.
    a_r5_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_sel == 3'd4) |=> res_q[DW-1] == $past(acc_in[DW-1]));

    // R8: the index pair is untouched except by its own adjust.
    a_r8_hx_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_sel != 3'd6) |=> hx_q == $past(hx_in));
endmodule

// File: tb/tb_accu_alu_top.sv
module tb_accu_alu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_en = 1'b0;
    logic [2:0]  op_sel = '0;
    logic [7:0]  acc_in = '0, opnd_in = '0;
    logic [5:0]  ccr_in = '0;
    logic [15:0] sp_in = '0, hx_in = '0;
    logic [7:0]  res_q;
    logic [5:0]  ccr_q;
    logic [15:0] sp_q, hx_q;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    accu_alu_top dut (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_sel(op_sel),
        .acc_in(acc_in), .opnd_in(opnd_in), .ccr_in(ccr_in),
        .sp_in(sp_in), .hx_in(hx_in),
        .res_q(res_q), .ccr_q(ccr_q), .sp_q(sp_q), .hx_q(hx_q)
    );

    // {op, acc, opnd, ccr_in, exp_res, exp_ccr}; CCR = {V,H,I,N,Z,C}
    localparam logic [38:0] VEC [14] = '{
        {3'd0, 8'h3A, 8'h17, 6'h00, 8'h51, 6'h10},  // R1 nibble carry only
        {3'd0, 8'h7F, 8'h01, 6'h00, 8'h80, 6'h34},  // R1 signed overflow
        {3'd0, 8'hFF, 8'h01, 6'h08, 8'h00, 6'h1B},  // R1 R9 wrap, I kept
        {3'd1, 8'h10, 8'h20, 6'h01, 8'h31, 6'h00},  // R2 carry-in
        {3'd1, 8'hFF, 8'h00, 6'h01, 8'h00, 6'h13},  // R2 carry ripples
        {3'd2, 8'hF0, 8'h8F, 6'h31, 8'h80, 6'h15},  // R3 H,C kept, V cleared
        {3'd2, 8'h0F, 8'hF0, 6'h00, 8'h00, 6'h02},  // R3 R6 zero
        {3'd3, 8'h81, 8'h00, 6'h10, 8'h02, 6'h31},  // R4 carry out, H kept
        {3'd3, 8'h40, 8'h00, 6'h00, 8'h80, 6'h24},  // R4 sign change
        {3'd4, 8'h81, 8'h00, 6'h00, 8'hC0, 6'h05},  // R5 sign fill
        {3'd4, 8'h01, 8'h00, 6'h08, 8'h00, 6'h2B},  // R5 R6 R9 zero, I kept
        {3'd4, 8'h7E, 8'h00, 6'h00, 8'h3F, 6'h00},  // R5 plain
        {3'd5, 8'h55, 8'hFE, 6'h2A, 8'h55, 6'h2A},  // R10 pointer op
        {3'd7, 8'hA5, 8'h33, 6'h15, 8'hA5, 6'h15}   // R10 no-op
    };

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0: return "R1 R6";
            3'd1: return "R2 R6";
            3'd2: return "R3 R6";
            3'd3: return "R4 R6";
            3'd4: return "R5 R6";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [2:0] op, input logic [7:0] a, input logic [7:0] m,
                         input logic [5:0] c, input logic [15:0] sp, input logic [15:0] hx);
        @(negedge clk);
        op_sel = op; acc_in = a; opnd_in = m; ccr_in = c; sp_in = sp; hx_in = hx;
        upd_en = 1'b1;
        @(posedge clk); #1;
        upd_en = 1'b0;
    endtask

    initial begin : watchdog
        #1000000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        upd_en = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        // R12 reset state
        check("R12 res", {8'h0, res_q}, 16'h0);
        check("R12 ccr", {10'h0, ccr_q}, 16'h0);
        check("R12 sp", sp_q, 16'h0);
        @(negedge clk);
        upd_en = 1'b0;
        rst_n = 1'b1;

        for (int i = 0; i < 14; i++) begin
            apply(VEC[i][38:36], VEC[i][35:28], VEC[i][27:20], VEC[i][19:14], 16'h4000, 16'h2000);
            check({tag_of(VEC[i][38:36]), " res"}, {8'h0, res_q}, {8'h0, VEC[i][13:6]});
            check({tag_of(VEC[i][38:36]), " ccr"}, {10'h0, ccr_q}, {10'h0, VEC[i][5:0]});
        end

        // R7 negative immediate moves SP down; R8 index pair passes through
        apply(3'd5, 8'h00, 8'hFE, 6'h00, 16'h0100, 16'h1234);
        check("R7 sp", sp_q, 16'h00FE);
        check("R8 hx pass", hx_q, 16'h1234);
        // R8 positive adjust crosses a byte; R7 SP passes through
        apply(3'd6, 8'h00, 8'h01, 6'h00, 16'hBEEF, 16'h00FF);
        check("R8 hx", hx_q, 16'h0100);
        check("R7 sp pass", sp_q, 16'hBEEF);
        // R8 wrap modulo 2^16
        apply(3'd6, 8'h00, 8'h7F, 6'h3F, 16'h0000, 16'hFFFF);
        check("R8 hx wrap", hx_q, 16'h007E);
        check("R10 R9 ccr pass", {10'h0, ccr_q}, 16'h003F);
        // R7 negative wrap below zero
        apply(3'd5, 8'h00, 8'h80, 6'h00, 16'h0010, 16'h0000);
        check("R7 sp wrap", sp_q, 16'hFF90);

        // R11 hold with enable low while inputs change
        @(negedge clk);
        op_sel = 3'd0; acc_in = 8'h11; opnd_in = 8'h22; ccr_in = 6'h3F;
        sp_in = 16'hAAAA; hx_in = 16'h5555; upd_en = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R11 res hold", {8'h0, res_q}, 16'h0000);
        check("R11 sp hold", sp_q, 16'hFF90);
        check("R11 hx hold", hx_q, 16'h0000);

        // R12 reset with enable low still clears
        apply(3'd0, 8'h12, 8'h34, 6'h00, 16'h1111, 16'h2222);
        check("R1 pre-reset", {8'h0, res_q}, 16'h0046);
        @(negedge clk);
        rst_n = 1'b0; upd_en = 1'b0;
        @(posedge clk); #1;
        check("R12 res clr", {8'h0, res_q}, 16'h0);
        check("R12 hx clr", hx_q, 16'h0);
        check("R12 sp clr", sp_q, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule